// File: doc/BRIEF.md
# Vector Bit-Gather Mask Unit

This unit collects single bits out of a wide data vector and packs them into a narrow mask word. The data vector is cut into 64-bit lanes, and each lane has eight control bytes beside it. Every control byte names one bit inside its own lane's data word, so each lane yields eight result bits. The result bits of lane 0 fill mask positions 0 to 7, the bits of lane 1 fill positions 8 to 15, and so on upward.

A vector-length select chooses how many lanes are active: two, four or eight. A zeroing write mask can be enabled to force chosen result positions to zero. Operands are captured in one clock when the input valid is high. The mask result and its valid flag appear on the next clock. The unit produces the mask and nothing else.

Top module: `bitgather_mask_unit`

## Requirements
- R1: Result bit `i*8+j` equals bit `m` of data lane `i` (data_vec bits `64*i+63` down to `64*i`), where `m` is control byte `j` of lane `i`, that is ctrl_vec bits `8*(8*i+j)+5` down to `8*(8*i+j)`.
- R2: Only bits 5:0 of each control byte form the index. Control bytes whose bits 7:6 are set (for example 8'hFF or 8'hC5) select the same data bit as the byte with those two bits cleared, and they do not force a zero.
- R3: No result bit depends on data outside its own 64-bit lane.
- R4: vlen_sel 2'b00 makes 16 result bits active (2 lanes), 2'b01 makes 32 active (4 lanes), 2'b10 makes 64 active (8 lanes), and the reserved code 2'b11 behaves as 2'b10.
- R5: When wmask_en is 1, every result position whose wmask bit is 0 reads 0.
- R6: When wmask_en is 0, wmask has no effect and every active position is computed.
- R7: Every result bit at or above the active count chosen by vlen_sel reads 0.
- R8: A result is captured on a clock edge where in_valid is 1. mask_out shows it after that edge and out_valid is 1. After an edge where in_valid is 0, out_valid is 0.
- R9: mask_out keeps its previous value across edges where in_valid is 0.
- R10: A synchronous active-high rst clears out_valid and mask_out to 0 on the next edge, whatever in_valid is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are valid this cycle |
| data_vec | input | 512 | Data vector, eight 64-bit lanes |
| ctrl_vec | input | 512 | Control vector, one index byte per result bit |
| wmask | input | 64 | Zeroing write mask, one bit per result position |
| wmask_en | input | 1 | Applies wmask when 1 |
| vlen_sel | input | 2 | Vector-length code: 00=128, 01=256, 10/11=512 |
| out_valid | output | 1 | mask_out holds a fresh result |
| mask_out | output | 64 | Gathered mask result |

## Verification
The bench builds the unit with its default parameters: eight lanes of 64 bits, eight selectors per lane, byte-wide control and a two-lane minimum length. This reaches all four vector-length codes, so the clearing boundaries at bits 16 and 32 and the full 64-bit result can each be tested. With one index byte per result bit, the lane-isolation patterns, the all-63 indexes and the control bytes with their high bits set each reach every selector in every lane.

// File: rtl/bitgather_pkg.sv
package bitgather_pkg;

   typedef enum logic [1:0] {
      VLEN_SHORT = 2'b00,
      VLEN_MID   = 2'b01,
      VLEN_FULL  = 2'b10,
      VLEN_RSVD  = 2'b11
   } vlen_code_e;

   // Lanes active for a length code: doubling per code step, capped at the lane count.
   function automatic int lanes_for_code(input vlen_code_e code, input int min_lanes,
                                         input int num_lanes);
      int lanes;
      lanes = min_lanes;
      for (int s = 0; s < int'(code); s++) begin
         lanes = lanes * 2;
      end
      if (lanes > num_lanes) begin
         lanes = num_lanes;
      end
      return lanes;
   endfunction

endpackage

// File: rtl/bg_lane_select.sv
module bg_lane_select #(
   parameter int LANE_W        = 64,
   parameter int SELS_PER_LANE = 8,
   parameter int CTRL_W        = 8,
   parameter int SEL_STYLE     = 0,
   localparam int IDX_W        = $clog2(LANE_W)
) (
   input  logic [LANE_W-1:0]               lane_data,
   input  logic [SELS_PER_LANE*CTRL_W-1:0] lane_ctrl,
   output logic [SELS_PER_LANE-1:0]        lane_bits
);

   logic [SELS_PER_LANE-1:0] hi_fold;

   for (genvar j = 0; j < SELS_PER_LANE; j++) begin : g_sel
      logic [IDX_W-1:0] idx;
      assign idx = lane_ctrl[j*CTRL_W +: IDX_W];

      if (CTRL_W > IDX_W) begin : g_hi
         assign hi_fold[j] = ^lane_ctrl[j*CTRL_W+IDX_W +: CTRL_W-IDX_W];
      end else begin : g_nohi
         assign hi_fold[j] = 1'b0;
      end

      if (SEL_STYLE == 0) begin : g_mux
         assign lane_bits[j] = lane_data[idx];
      end else begin : g_onehot
         logic [LANE_W-1:0] pick;
         assign pick         = LANE_W'(1) << idx;
         assign lane_bits[j] = |(lane_data & pick);
      end
   end

   // Index bytes carry bits above the index width that the gather never reads.
   logic ctrl_hi_unused;
   assign ctrl_hi_unused = ^hi_fold;

endmodule

// File: rtl/bg_enable_mask.sv
module bg_enable_mask
   import bitgather_pkg::*;
#(
   parameter int NUM_LANES     = 8,
   parameter int SELS_PER_LANE = 8,
   parameter int MIN_LANES     = 2,
   localparam int OUT_W        = NUM_LANES * SELS_PER_LANE
) (
   input  logic [1:0]       vlen_sel,
   input  logic [OUT_W-1:0] wmask,
   input  logic             wmask_en,
   output logic [OUT_W-1:0] keep_bits
);

   int lane_lim;

   always_comb begin
      lane_lim = lanes_for_code(vlen_code_e'(vlen_sel), MIN_LANES, NUM_LANES);
   end

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      logic lane_on;
      assign lane_on = (l < lane_lim);
      for (genvar j = 0; j < SELS_PER_LANE; j++) begin : g_pos
         localparam int P = l*SELS_PER_LANE + j;
         assign keep_bits[P] = lane_on & (~wmask_en | wmask[P]);
      end
   end

endmodule

// File: rtl/bitgather_mask_unit.sv
module bitgather_mask_unit #(
   parameter int LANE_W        = 64,
   parameter int SELS_PER_LANE = 8,
   parameter int CTRL_W        = 8,
   parameter int NUM_LANES     = 8,
   parameter int MIN_LANES     = 2,
   parameter int SEL_STYLE     = 0,
   localparam int DATA_W       = NUM_LANES * LANE_W,
   localparam int OUT_W        = NUM_LANES * SELS_PER_LANE,
   localparam int CVEC_W       = OUT_W * CTRL_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] data_vec,
   input  logic [CVEC_W-1:0] ctrl_vec,
   input  logic [OUT_W-1:0]  wmask,
   input  logic              wmask_en,
   input  logic [1:0]        vlen_sel,
   output logic              out_valid,
   output logic [OUT_W-1:0]  mask_out
);

   localparam int IDX_W     = $clog2(LANE_W);
   localparam int LCTRL_W   = SELS_PER_LANE * CTRL_W;

   if (LANE_W != (1 << IDX_W)) begin : g_chk_lane
      $error("LANE_W must be a power of two");
   end
   if (CTRL_W < IDX_W) begin : g_chk_ctrl
      $error("CTRL_W must hold a full lane index");
   end
   if (MIN_LANES < 1 || MIN_LANES > NUM_LANES) begin : g_chk_min
      $error("MIN_LANES must lie in 1..NUM_LANES");
   end
   if (SEL_STYLE != 0 && SEL_STYLE != 1) begin : g_chk_style
      $error("SEL_STYLE must be 0 or 1");
   end

   logic [OUT_W-1:0] gathered;
   logic [OUT_W-1:0] keep_bits;
   logic [OUT_W-1:0] result_d;

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      bg_lane_select #(
         .LANE_W       (LANE_W),
         .SELS_PER_LANE(SELS_PER_LANE),
         .CTRL_W       (CTRL_W),
         .SEL_STYLE    (SEL_STYLE)
      ) u_sel (
         .lane_data(data_vec[i*LANE_W +: LANE_W]),
         .lane_ctrl(ctrl_vec[i*LCTRL_W +: LCTRL_W]),
         .lane_bits(gathered[i*SELS_PER_LANE +: SELS_PER_LANE])
      );
   end

   bg_enable_mask #(
      .NUM_LANES    (NUM_LANES),
      .SELS_PER_LANE(SELS_PER_LANE),
      .MIN_LANES    (MIN_LANES)
   ) u_enable (
      .vlen_sel (vlen_sel),
      .wmask    (wmask),
      .wmask_en (wmask_en),
      .keep_bits(keep_bits)
   );

   assign result_d = gathered & keep_bits;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         mask_out  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            mask_out <= result_d;
         end
      end
   end

endmodule

// File: rtl/bitgather_mask_unit_chk.sv
module bitgather_mask_unit_chk #(
   parameter int LANE_W        = 64,
   parameter int SELS_PER_LANE = 8,
   parameter int CTRL_W        = 8,
   parameter int NUM_LANES     = 8,
   parameter int MIN_LANES     = 2,
   localparam int DATA_W       = NUM_LANES * LANE_W,
   localparam int OUT_W        = NUM_LANES * SELS_PER_LANE,
   localparam int CVEC_W       = OUT_W * CTRL_W,
   localparam int IDX_W        = $clog2(LANE_W)
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [DATA_W-1:0] data_vec,
   input logic [CVEC_W-1:0] ctrl_vec,
   input logic [OUT_W-1:0]  wmask,
   input logic              wmask_en,
   input logic [1:0]        vlen_sel,
   input logic              out_valid,
   input logic [OUT_W-1:0]  mask_out
);

   localparam int SHORT_BITS = MIN_LANES * SELS_PER_LANE;
   localparam int MID_BITS   = 2 * MIN_LANES * SELS_PER_LANE;

   a_r10_reset_clears: assert property (@(posedge clk)
      rst |=> (!out_valid && mask_out == '0));

   a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   a_r8_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   a_r9_hold_result: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(mask_out));

   a_r5_zeroing: assert property (@(posedge clk) disable iff (rst)
      (in_valid && wmask_en) |=> ((mask_out & ~$past(wmask)) == '0));

   a_r7_clear_short: assert property (@(posedge clk) disable iff (rst)
      (in_valid && vlen_sel == 2'b00) |=> ((mask_out >> SHORT_BITS) == '0));

   a_r7_clear_mid: assert property (@(posedge clk) disable iff (rst)
      (in_valid && vlen_sel == 2'b01) |=> ((mask_out >> MID_BITS) == '0));

   // R1 and R2: lowest result bit gathers from lane 0 using only the low index bits.
   a_r1_first_bit: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !wmask_en) |=>
         (mask_out[0] == $past(data_vec[ctrl_vec[IDX_W-1:0]])));

   // R3: highest result bit of a full-length run gathers from the top lane only.
   a_r3_top_lane: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !wmask_en && vlen_sel[1]) |=>
         (mask_out[OUT_W-1] ==
          $past(data_vec[DATA_W-LANE_W + int'(ctrl_vec[CTRL_W*(OUT_W-1) +: IDX_W])])));

endmodule

bind bitgather_mask_unit bitgather_mask_unit_chk #(
   .LANE_W       (LANE_W),
   .SELS_PER_LANE(SELS_PER_LANE),
   .CTRL_W       (CTRL_W),
   .NUM_LANES    (NUM_LANES),
   .MIN_LANES    (MIN_LANES)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .data_vec (data_vec),
   .ctrl_vec (ctrl_vec),
   .wmask    (wmask),
   .wmask_en (wmask_en),
   .vlen_sel (vlen_sel),
   .out_valid(out_valid),
   .mask_out (mask_out)
);

// File: tb/bitgather_mask_unit_tb_top.sv
`timescale 1ns/1ps
module bitgather_mask_unit_tb_top;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [511:0] data_vec = '0;
   logic [511:0] ctrl_vec = '0;
   logic [63:0]  wmask = '0;
   logic         wmask_en = 1'b0;
   logic [1:0]   vlen_sel = 2'b10;
   logic         out_valid;
   logic [63:0]  mask_out;

   int n_chk  = 0;
   int n_fail = 0;

   logic        exp_v = 1'b0;
   logic [63:0] exp_m = '0;
   logic [63:0] exp_q[$];

   always #2 clk = ~clk;

   bitgather_mask_unit dut_i (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .data_vec (data_vec),
      .ctrl_vec (ctrl_vec),
      .wmask    (wmask),
      .wmask_en (wmask_en),
      .vlen_sel (vlen_sel),
      .out_valid(out_valid),
      .mask_out (mask_out)
   );

   function automatic logic [511:0] rnd512();
      logic [511:0] r;
      for (int k = 0; k < 16; k++) r[k*32 +: 32] = $urandom;
      return r;
   endfunction

   function automatic logic [63:0] rnd64();
      return {$urandom, $urandom};
   endfunction

   // Behavioural reference: walk every result position in turn.
   function automatic logic [63:0] model(input logic [511:0] d, input logic [511:0] c,
                                         input logic [63:0] w, input logic en,
                                         input logic [1:0] vl);
      logic [63:0] res;
      int lanes;
      res = '0;
      case (vl)
         2'b00:   lanes = 2;
         2'b01:   lanes = 4;
         default: lanes = 8;
      endcase
      for (int b = 0; b < 64; b++) begin
         int lane;
         int idx;
         lane = b / 8;
         idx  = int'(c[b*8 +: 8]) % 64;
         if (lane < lanes && (!en || w[b])) res[b] = d[lane*64 + idx];
      end
      return res;
   endfunction

   task automatic check_outputs(input string tag);
      n_chk++;
      if (out_valid !== exp_v) begin
         n_fail++;
         $display("FAIL %s out_valid got %0b exp %0b", tag, out_valid, exp_v);
      end
      n_chk++;
      if (mask_out !== exp_m) begin
         n_fail++;
         $display("FAIL %s mask_out got %h exp %h", tag, mask_out, exp_m);
      end
   endtask

   // One clock: check what the last edge produced, then drive the next operands.
   task automatic cycle(input logic r, input logic v, input logic [511:0] d,
                        input logic [511:0] c, input logic [63:0] w, input logic en,
                        input logic [1:0] vl, input string tag);
      @(negedge clk);
      if (exp_q.size() > 0) exp_m = exp_q.pop_front();
      check_outputs(tag);
      rst = r; in_valid = v; data_vec = d; ctrl_vec = c;
      wmask = w; wmask_en = en; vlen_sel = vl;
      if (r) begin
         exp_v = 1'b0;
         exp_q.push_back(64'h0);
      end else begin
         exp_v = v;
         exp_q.push_back(v ? model(d, c, w, en, vl) : exp_m);
      end
   endtask

   initial begin : watchdog
      #(4 * 100000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      logic [511:0] d;
      logic [511:0] c;
      // R10: reset held while operands are offered
      for (int k = 0; k < 3; k++) cycle(1'b1, 1'b1, rnd512(), rnd512(), rnd64(), 1'b0, 2'b10, "R10");
      // R1: random full-length gathers, no masking
      for (int k = 0; k < 24; k++) cycle(1'b0, 1'b1, rnd512(), rnd512(), rnd64(), 1'b0, 2'b10, "R1");
      // R1: every index is 63
      for (int k = 0; k < 4; k++) cycle(1'b0, 1'b1, rnd512(), {64{8'h3F}}, '0, 1'b0, 2'b10, "R1");
      // R2: high index bits set, all 8'hFF and random with 8'hC0 ORed in
      for (int k = 0; k < 4; k++) cycle(1'b0, 1'b1, rnd512(), {64{8'hFF}}, '0, 1'b0, 2'b10, "R2");
      for (int k = 0; k < 8; k++) cycle(1'b0, 1'b1, rnd512(), rnd512() | {64{8'hC0}}, '0, 1'b0, 2'b10, "R2");
      // R3: one lane loaded, the others opposite, per lane
      for (int l = 0; l < 8; l++) begin
         d = '0;
         d[l*64 +: 64] = 64'hFFFF_FFFF_FFFF_FFFF;
         cycle(1'b0, 1'b1, d, rnd512(), '0, 1'b0, 2'b10, "R3");
         cycle(1'b0, 1'b1, ~d, rnd512(), '0, 1'b0, 2'b10, "R3");
      end
      // R4 and R7: each length code, including the reserved one
      for (int k = 0; k < 4; k++) begin
         for (int vl = 0; vl < 4; vl++) begin
            cycle(1'b0, 1'b1, {512{1'b1}}, rnd512(), '0, 1'b0, 2'(vl), "R4");
            cycle(1'b0, 1'b1, rnd512(), rnd512(), rnd64(), 1'($urandom), 2'(vl), "R7");
         end
      end
      // R5: masking on with an all-zero mask, then random masks
      for (int k = 0; k < 4; k++) cycle(1'b0, 1'b1, {512{1'b1}}, rnd512(), '0, 1'b1, 2'b10, "R5");
      for (int k = 0; k < 8; k++) cycle(1'b0, 1'b1, rnd512(), rnd512(), rnd64(), 1'b1, 2'b10, "R5");
      // R6: masking off, mask bits zero
      for (int k = 0; k < 4; k++) cycle(1'b0, 1'b1, {512{1'b1}}, rnd512(), '0, 1'b0, 2'b10, "R6");
      // R9: idle cycles with moving operands
      for (int k = 0; k < 6; k++) cycle(1'b0, 1'b0, rnd512(), rnd512(), rnd64(), 1'($urandom), 2'($urandom), "R9");
      // R8: valid toggling
      for (int k = 0; k < 16; k++) begin
         c = rnd512();
         cycle(1'b0, 1'($urandom), rnd512(), c, rnd64(), 1'($urandom), 2'($urandom), "R8");
      end
      // R10: reset again mid-stream
      cycle(1'b1, 1'b1, rnd512(), rnd512(), rnd64(), 1'b0, 2'b10, "R10");
      cycle(1'b0, 1'b0, rnd512(), rnd512(), rnd64(), 1'b0, 2'b10, "R10");
      cycle(1'b0, 1'b0, '0, '0, '0, 1'b0, 2'b10, "R9");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule